// File: doc/BRIEF.md
# UART Receive Buffer with Watermark-Driven DMA Request

This block sits between the character assembler of a UART receiver and a DMA engine. Each received character arrives as a one-cycle strobe with its data byte and goes into a small first-in first-out store. The store is 16 entries deep by default. A two-bit trigger selector gives the fill threshold. The block holds a level-sensitive service request to the DMA engine high while the occupancy is at or above that threshold.

The DMA engine drains the store in bursts. It reads one entry per beat through a show-ahead read port, so the head entry is presented in the same cycle as the read strobe. Two error conditions are detected and held in sticky flags. Overflow means a character arrived with no room left and was dropped. Underflow means a read came while nothing was stored. A single-cycle clear input resets both flags. A separate synchronous flush empties the store, drops the request and clears both flags.

Characters may keep arriving while a burst is in progress. A write and a read in the same cycle are both served. If the burst length matches the occupancy seen at request time, the burst can leave the store exactly empty with no error. If characters arrive during the burst, the store is left non-empty.

Top module: `uart_rxq_dma`

## Requirements
- R1: After `rst` is held high across a clock edge, `level` is 0, `empty` is 1, `full` is 0, `dma_req` is 0, and both error flags are 0.
- R2: Accepted characters leave in arrival order. While `rd_en` is high and the store is not empty, `rd_valid` is 1 and `rd_data` shows the oldest entry in that same cycle. The entry is removed at the next clock edge.
- R3: A character strobed while `level` equals the depth, with no read in that cycle, is dropped. `level` stays at the depth and `ovf_flag` reads 1 from the next cycle.
- R4: A read strobed while `level` is 0 returns `rd_valid` 0 and `rd_data` 0. `udf_flag` reads 1 from the next cycle.
- R5: `trig_sel` decodes to a watermark: 2'b00 is 1 entry, 2'b01 is depth/4 (4), 2'b10 is depth/2 (8), and 2'b11 is depth-2 (14).
- R6: `dma_req` is high exactly when `level` is at or above the decoded watermark. It falls in the cycle after the edge that takes `level` below the watermark. It rises again, with no other handshake, once `level` reaches the watermark.
- R7: A write and a read in the same cycle on a non-empty store are both served and `level` is unchanged. This also holds when the store is full, and in that case no overflow is flagged. On an empty store, the write is accepted and the read counts as an underflow.
- R8: A burst of N reads starting at `level` N leaves `level` at 0 and `udf_flag` at 0. If K characters are written during that burst, the store ends it holding K entries.
- R9: Both error flags stay set until `err_clr` is high at a clock edge. A new error event in the same cycle as `err_clr` leaves its flag set.
- R10: `fifo_clr` high at a clock edge empties the store, clears both flags and drops `dma_req`. Any write or read in that cycle is ignored, and `rd_valid` is 0 while `fifo_clr` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Synchronous flush of store, request and flags |
| err_clr | input | 1 | Single-cycle clear of both sticky error flags |
| trig_sel | input | 2 | Watermark selector |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rd_en | input | 1 | DMA read beat strobe |
| rd_data | output | 8 | Head entry; 0 when the read is not served |
| rd_valid | output | 1 | Read beat served this cycle |
| dma_req | output | 1 | Level-sensitive service request |
| level | output | 5 | Current occupancy |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | Occupancy is zero |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
Directed sequences come first.
- Filling the store under each trigger value shows the exact level at which the request rises. This separates the four decodes from each other and from an off-by-one compare.
- A burst that matches the occupancy is set against one read beyond it, which separates a clean drain from a true underflow.
- Simultaneous read and write are applied on a full store and on an empty one, which separates "both served" from "overflow" and from "underflow".
- Clear and flush are applied together with new error events, which exposes the wrong priority.

A long seeded random mix of writes, reads, trigger changes and clears follows. It compares the data order, occupancy and flags every cycle against a queue model, which catches pointer-wrap and count-update faults.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE       = 2'b00,
        TRIG_QUARTER   = 2'b01,
        TRIG_HALF      = 2'b10,
        TRIG_NEAR_FULL = 2'b11
    } trig_e;

    // Per-cycle decision for the store, derived from the strobes and state.
    typedef struct packed {
        logic push;     // character accepted into the store
        logic pop;      // head entry consumed by the DMA side
        logic ovf_ev;   // character dropped for lack of space
        logic udf_ev;   // read on an empty store
    } qop_t;

    localparam int unsigned NUM_ERR = 2;
    localparam int unsigned ERR_OVF = 0;
    localparam int unsigned ERR_UDF = 1;

    function automatic int unsigned wm_entries(trig_e sel, int unsigned depth);
        case (sel)
            TRIG_ONE:       return 1;
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            default:        return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  uart_rxq_pkg::qop_t   op,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        head,
    output logic [CW-1:0]        count,
    output logic                 is_full,
    output logic                 is_empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.push) wr_ptr <= wr_ptr + AW'(1);
            if (op.pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({op.push, op.pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && op.push) mem[wr_ptr] <= wr_data;
    end

    assign head     = mem[rd_ptr];
    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);

endmodule

// File: rtl/rxq_watermark.sv
module rxq_watermark #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic [1:0]    trig,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] mark,
    output logic          req
);
    import uart_rxq_pkg::*;

    logic [CW-1:0] lut [4];

    // One threshold per selector code, computed at elaboration.
    for (genvar g = 0; g < 4; g++) begin : g_mark
        localparam int unsigned ENT = wm_entries(trig_e'(g), DEPTH);
        localparam int unsigned CLP = (ENT < 1) ? 1 : ENT;
        assign lut[g] = CW'(CLP);
    end

    assign mark = lut[trig];
    assign req  = (count >= mark);

endmodule

// File: rtl/rxq_errflags.sv
module rxq_errflags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         clr,
    input  logic [N-1:0] ev,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || flush)  flag[i] <= 1'b0;
            else if (ev[i])    flag[i] <= 1'b1;
            else if (clr)      flag[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rxq_dma.sv
module uart_rxq_dma #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_clr,
    input  logic          err_clr,
    input  logic [1:0]    trig_sel,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          dma_req,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovf_flag,
    output logic          udf_flag
);
    import uart_rxq_pkg::*;

    qop_t                op;
    logic [DW-1:0]       head;
    logic [CW-1:0]       mark;
    logic [NUM_ERR-1:0]  err_ev, err_q;
    logic                req_raw;

    always_comb begin
        op        = '0;
        op.pop    = rd_en && !empty && !fifo_clr;
        op.push   = rx_valid && !fifo_clr && (!full || op.pop);
        op.ovf_ev = rx_valid && !fifo_clr && full && !op.pop;
        op.udf_ev = rd_en && !fifo_clr && empty;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (fifo_clr),
        .op       (op),
        .wr_data  (rx_data),
        .head     (head),
        .count    (level),
        .is_full  (full),
        .is_empty (empty)
    );

    rxq_watermark #(.DEPTH(DEPTH)) u_mark (
        .trig  (trig_sel),
        .count (level),
        .mark  (mark),
        .req   (req_raw)
    );

    assign err_ev[ERR_OVF] = op.ovf_ev;
    assign err_ev[ERR_UDF] = op.udf_ev;

    rxq_errflags #(.N(NUM_ERR)) u_err (
        .clk   (clk),
        .rst   (rst),
        .flush (fifo_clr),
        .clr   (err_clr),
        .ev    (err_ev),
        .flag  (err_q)
    );

    assign rd_valid = op.pop;
    assign rd_data  = op.pop ? head : '0;
    assign dma_req  = req_raw && (mark != '0);
    assign ovf_flag = err_q[ERR_OVF];
    assign udf_flag = err_q[ERR_UDF];

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_clr,
    input logic          err_clr,
    input logic [1:0]    trig_sel,
    input logic          rx_valid,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          dma_req,
    input logic [CW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          ovf_flag,
    input logic          udf_flag
);
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    assert_no_valid_on_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid |-> !empty) and (!rd_valid |-> rd_data == '0));

    assert_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && full && !rd_en && !fifo_clr) |=> (ovf_flag && full));

    assert_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !fifo_clr) |=> udf_flag);

    assert_full_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rd_en && full && !fifo_clr && !ovf_flag) |=> (full && !ovf_flag));

    assert_req_rise_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(dma_req) && $stable(trig_sel)) |-> (level > $past(level)));

    assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !err_clr && !fifo_clr) |=> ovf_flag);

    assert_sticky_udf_R9: assert property (@(posedge clk) disable iff (rst)
        (udf_flag && !err_clr && !fifo_clr) |=> udf_flag);

    assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (empty && !dma_req && !ovf_flag && !udf_flag));

endmodule

bind uart_rxq_dma rxq_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_clr (fifo_clr),
    .err_clr  (err_clr),
    .trig_sel (trig_sel),
    .rx_valid (rx_valid),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .dma_req  (dma_req),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .ovf_flag (ovf_flag),
    .udf_flag (udf_flag)
);

// File: tb/tb_uart_rxq_dma.sv
`timescale 1ns/1ps
module tb_uart_rxq_dma;
    localparam int D = 16;

    logic       clk = 0;
    logic       rst, fifo_clr, err_clr, rx_valid, rd_en;
    logic [1:0] trig_sel;
    logic [7:0] rx_data, rd_data;
    logic       rd_valid, dma_req, full, empty, ovf_flag, udf_flag;
    logic [4:0] level;

    int n_cmp = 0, n_bad = 0;
    int q[$];
    bit m_ovf = 0, m_udf = 0;

    always #5 clk = ~clk;

    uart_rxq_dma dut (
        .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .err_clr(err_clr),
        .trig_sel(trig_sel), .rx_valid(rx_valid), .rx_data(rx_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .dma_req(dma_req), .level(level),
        .full(full), .empty(empty), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    function automatic int wm_exp(logic [1:0] t);
        case (t)
            2'b00: return 1;
            2'b01: return D / 4;
            2'b10: return D / 2;
            default: return D - 2;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_state(string tag);
        int sz = q.size();
        chk(level == sz, {"R2 ", tag}, "level", level, sz);
        chk(full == (sz == D), {"R3 ", tag}, "full", full, sz == D);
        chk(empty == (sz == 0), {"R4 ", tag}, "empty", empty, sz == 0);
        chk(ovf_flag == m_ovf, {"R3 ", tag}, "ovf_flag", ovf_flag, m_ovf);
        chk(udf_flag == m_udf, {"R4 ", tag}, "udf_flag", udf_flag, m_udf);
        chk(dma_req == (sz >= wm_exp(trig_sel)), {"R6 ", tag}, "dma_req", dma_req,
            sz >= wm_exp(trig_sel));
    endtask

    // One cycle: drive at negedge, check read port, clock, update model, check state.
    task automatic step(bit wr, logic [7:0] d, bit rd, bit ec, bit fc, string tag);
        bit rok, wok, oev, uev;
        rx_valid = wr; rx_data = d; rd_en = rd; err_clr = ec; fifo_clr = fc;
        #1;
        rok = rd && !fc && q.size() > 0;
        chk(rd_valid == rok, {"R2 ", tag}, "rd_valid", rd_valid, rok);
        chk(rd_data == (rok ? q[0] : 0), {"R2 ", tag}, "rd_data", rd_data, rok ? q[0] : 0);
        @(posedge clk);
        if (fc) begin
            q.delete(); m_ovf = 0; m_udf = 0;
        end else begin
            wok = wr && (q.size() < D || rok);
            oev = wr && !wok;
            uev = rd && q.size() == 0;
            if (rok) void'(q.pop_front());
            if (wok) q.push_back(d);
            m_ovf = oev ? 1'b1 : (ec ? 1'b0 : m_ovf);
            m_udf = uev ? 1'b1 : (ec ? 1'b0 : m_udf);
        end
        @(negedge clk);
        rx_valid = 0; rd_en = 0; err_clr = 0; fifo_clr = 0;
        chk_state(tag);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; fifo_clr = 0; err_clr = 0; rx_valid = 0; rd_en = 0;
        rx_data = 0; trig_sel = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk_state("R1 reset");

        // R5/R6: fill under each trigger code, request must rise exactly at its mark
        for (int t = 0; t < 4; t++) begin
            trig_sel = 2'(t);
            step(0, 0, 0, 0, 1, "R10 flush");
            for (int k = 0; k < D; k++) begin
                step(1, 8'(k + 16 * t), 0, 0, 0, "R5 fill");
                chk(dma_req == (k + 1 >= wm_exp(2'(t))), "R5", "req at level",
                    dma_req, k + 1 >= wm_exp(2'(t)));
            end
        end

        // R3: overflow on full store, then R9 clear
        step(1, 8'hAA, 0, 0, 0, "R3 ovf");
        step(0, 0, 0, 0, 0, "R9 hold");
        step(0, 0, 0, 1, 0, "R9 clear");
        // R7: full store, read+write, no overflow
        step(1, 8'h55, 1, 0, 0, "R7 full rw");
        // R6: drop below 14 then back
        trig_sel = 2'b11;
        step(0, 0, 1, 0, 0, "R6 d1");
        step(0, 0, 1, 0, 0, "R6 d2");
        step(0, 0, 1, 0, 0, "R6 below");
        step(1, 8'h11, 0, 0, 0, "R6 back");

        // R8: burst equal to occupancy
        trig_sel = 2'b01;
        step(0, 0, 0, 0, 1, "R10 flush");
        for (int k = 0; k < 4; k++) step(1, 8'(k + 1), 0, 0, 0, "R8 load");
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, "R8 burst");
        chk(level == 0 && !udf_flag, "R8", "clean drain", level, 0);
        // R4: one more read underflows
        step(0, 0, 1, 0, 0, "R4 udf");
        // R9: clear together with new underflow keeps flag
        step(0, 0, 1, 1, 0, "R9 set wins");
        step(0, 0, 0, 1, 0, "R9 clear");
        // R7: read+write on empty store
        step(1, 8'h77, 1, 0, 0, "R7 empty rw");
        // R8: writes during burst leave entries behind
        step(0, 0, 0, 1, 0, "R9 clear");
        for (int k = 0; k < 3; k++) step(1, 8'(k + 40), 0, 0, 0, "R8 load");
        for (int k = 0; k < 4; k++) step(k < 2, 8'(k + 90), 1, 0, 0, "R8 burst wr");
        chk(level == 2, "R8", "left after burst", level, 2);
        // R10: flush ignores concurrent write and read
        step(1, 8'h99, 1, 0, 1, "R10 flush rw");

        // Random mix
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) trig_sel = 2'($urandom_range(0, 3));
            step($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
                 $urandom_range(0, 99) < 4, r == 99, "rand");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule